// File: doc/BRIEF.md
# Power-Sequenced Serial ADC Conversion Controller

This block is the master side of a three-wire serial link to a sampling analog-to-digital converter. It drives an active-low chip select and a serial clock, and it receives the converter's serial data line. It also runs the converter's power sequence. The controller never knows whether the converter is awake after power-on, and it knows the converter is asleep after a shortened frame. In both cases it first runs a full-length wake-up frame and drops that frame's data. It then keeps chip select high for a quiet gap and runs the frame whose data is returned.

A request is accepted only while the block is idle, and the mode input is captured with it. In continuous mode every frame runs the full sixteen serial clock periods, so the converter stays awake and later requests need only one frame each. In power-save mode the serial clock still runs at full rate, but chip select rises right after the twelfth falling edge. The converter then shuts down until the next request, and that request again begins with a wake-up frame. The defaults give a conversion period of twenty serial clock periods including the quiet gap.

Top module: `adc_pwr_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, chip select and serial clock are high and busy and result valid are low.
- R2: The first request after reset, and every request that follows a power-save frame, produces a full-length wake-up frame and then a second frame, and only the second frame's data is reported.
- R3: The wake-up frame's data never reaches the result output; the reported result equals the data word the converter sent in the final frame of that request.
- R4: Between the end of any frame and the start of the next, chip select stays high for at least QUIET_CYC system clock cycles.
- R5: A continuous-mode frame has exactly FULL_LEN serial clock falling edges, consecutive falling edges are 2*CLK_DIV system cycles apart, and a request made while the converter is awake runs a single frame.
- R6: A power-save frame has exactly CUT_LEN (default 12) falling edges, so chip select rises after the 12th and before the 13th falling edge, and the result is still delivered.
- R7: The serial clock is high in every cycle in which chip select is high.
- R8: With frame bit index 0 present at the chip-select fall and index i following the i-th falling edge, the result takes indices LEAD_BITS to LEAD_BITS+RES_W-1, sampled on rising edges, most significant bit first.
- R9: Busy rises in the cycle after a request is accepted. Result valid is a single-cycle pulse, and busy is low in that same cycle.
- R10: A request or mode change made while busy is ignored: it starts no extra frame and does not alter the running frame's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_req | input | 1 | Conversion request, taken when not busy |
| psave_mode | input | 1 | 1 = power-save (short frame), 0 = continuous; captured with the request |
| busy | output | 1 | High from acceptance until the result is delivered |
| res_data | output | RES_W | Last reported conversion result |
| res_valid | output | 1 | One-cycle strobe marking a new result |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles high |
| adc_sdata | input | 1 | Serial data from the converter |

## Verification
The bench builds the block with CLK_DIV = 3 and QUIET_CYC = 7. An odd divider makes the serial clock period six system cycles, which tests the half-period counter at a value that is not a power of two. A quiet gap one cycle longer than a serial clock period puts the minimum gap check right at its limit. The converter model changes its data word on every frame. A reported dummy frame, a wrong bit window or reversed bit order therefore shows up as a result mismatch. The model also tracks the converter's own sleep state from the falling-edge count at which chip select rises.

// File: rtl/adc_pwr_pkg.sv
// Shared types for the serial converter controller.
package adc_pwr_pkg;
    // Sequencer states: idle, frame with chip select low, quiet gap with chip select high.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_QUIET = 2'd2
    } seq_state_t;
endpackage

// File: rtl/adc_sclk_timer.sv
// Serial clock generator. While run is high it counts system cycles and
// toggles the serial clock every DIV cycles. It starts high, so the first
// toggle is a falling edge. hp_next is the index the half-period counter
// takes at the next step: odd values are falling edges and even values
// are rising edges. Assumes run drops for at least one cycle between frames.
module adc_sclk_timer #(
    parameter int DIV = 2,
    parameter int HPW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    output logic           sclk,
    output logic           step,
    output logic [HPW-1:0] hp_next
);
    localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [TW-1:0]  tick;
    logic [HPW-1:0] hp;

    assign step    = run && (tick == TW'(DIV - 1));
    assign hp_next = hp + 1'b1;

    // Divide the system clock and count half periods during a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            tick <= '0;
            hp   <= '0;
            sclk <= 1'b1;
        end else if (step) begin
            tick <= '0;
            hp   <= hp_next;
            sclk <= ~sclk;
        end else begin
            tick <= tick + 1'b1;
        end
    end
endmodule

// File: rtl/adc_rx_shift.sv
// Receive path. On each rising serial clock edge whose index falls inside
// the data window it shifts one bit in, MSB first. The shift register is
// copied to the result output only when the sequencer delivers a valid
// frame, so dummy-frame bits never appear there.
module adc_rx_shift #(
    parameter int W    = 8,
    parameter int LEAD = 3,
    parameter int HPW  = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           step,
    input  logic [HPW-1:0] hp_next,
    input  logic           sdata,
    input  logic           deliver,
    output logic [W-1:0]   res_data
);
    localparam int LO = LEAD;
    localparam int HI = LEAD + W - 1;

    logic [W-1:0]   shreg;
    logic [HPW-2:0] rise_idx;
    logic           take;

    assign rise_idx = hp_next[HPW-1:1];
    assign take     = step && !hp_next[0] && (int'(rise_idx) >= LO) && (int'(rise_idx) <= HI);

    // Shift in data bits on rising edges inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n)    shreg <= '0;
        else if (take) shreg <= {shreg[W-2:0], sdata};
    end

    // Publish the word when a valid frame is delivered.
    always_ff @(posedge clk) begin
        if (!rst_n)       res_data <= '0;
        else if (deliver) res_data <= shreg;
    end
endmodule

// File: rtl/adc_pwr_seq.sv
// Power sequencer. It keeps a flag for whether the converter may be asleep.
// The flag is set at reset, because the power-on state is unknown, and
// after each power-save frame. When the flag is set, a request first runs
// a full dummy frame and a quiet gap. Every valid frame is then followed
// by a quiet gap before the result strobe. Frame length comes from the
// mode captured at acceptance.
module adc_pwr_seq
    import adc_pwr_pkg::*;
#(
    parameter int QUIET_CYC = 16,
    parameter int FULL_LEN  = 16,
    parameter int CUT_LEN   = 12,
    parameter int HPW       = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req,
    input  logic           psave_sel,
    input  logic           step,
    input  logic [HPW-1:0] hp_next,
    output logic           run,
    output logic           cs_n,
    output logic           busy,
    output logic           deliver,
    output logic           res_valid
);
    localparam int QW = $clog2(QUIET_CYC + 1);
    localparam logic [HPW-1:0] END_FULL = HPW'(2 * FULL_LEN);
    localparam logic [HPW-1:0] END_CUT  = HPW'(2 * CUT_LEN);

    seq_state_t     state;
    logic           asleep;
    logic           dummy;
    logic           psave_q;
    logic [QW-1:0]  qcnt;
    logic [HPW-1:0] end_hp;
    logic           frame_end;
    logic           q_done;

    assign end_hp    = (dummy || !psave_q) ? END_FULL : END_CUT;
    assign frame_end = step && (hp_next == end_hp);
    assign q_done    = (qcnt == QW'(QUIET_CYC - 1));
    assign run       = (state == ST_FRAME);
    assign cs_n      = !run;
    assign busy      = (state != ST_IDLE);
    assign deliver   = (state == ST_QUIET) && q_done && !dummy;

    // Step through idle, frame and quiet gap, and track the converter's power state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            asleep    <= 1'b1;
            dummy     <= 1'b0;
            psave_q   <= 1'b0;
            qcnt      <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        psave_q <= psave_sel;
                        dummy   <= asleep;
                        state   <= ST_FRAME;
                    end
                end
                ST_FRAME: begin
                    if (frame_end) begin
                        state  <= ST_QUIET;
                        qcnt   <= '0;
                        asleep <= dummy ? 1'b0 : psave_q;
                    end
                end
                ST_QUIET: begin
                    if (q_done) begin
                        if (dummy) begin
                            dummy <= 1'b0;
                            state <= ST_FRAME;
                        end else begin
                            state     <= ST_IDLE;
                            res_valid <= 1'b1;
                        end
                    end else begin
                        qcnt <= qcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_pwr_ctrl.sv
// Top level of the serial converter controller. It joins the serial clock
// timer, the power sequencer and the receive path. Assumes the converter
// changes its data line after serial clock falling edges and that
// QUIET_CYC is at least one serial clock period (2*CLK_DIV cycles).
module adc_pwr_ctrl #(
    parameter int CLK_DIV   = 2,
    parameter int RES_W     = 8,
    parameter int LEAD_BITS = 3,
    parameter int FULL_LEN  = 16,
    parameter int CUT_LEN   = 12,
    parameter int QUIET_CYC = 8 * CLK_DIV
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_req,
    input  logic             psave_mode,
    output logic             busy,
    output logic [RES_W-1:0] res_data,
    output logic             res_valid,
    output logic             adc_cs_n,
    output logic             adc_sclk,
    input  logic             adc_sdata
);
    localparam int HPW = $clog2(2 * FULL_LEN + 1);

    logic           run;
    logic           step;
    logic           deliver;
    logic [HPW-1:0] hp_next;

    adc_sclk_timer #(.DIV(CLK_DIV), .HPW(HPW)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run),
        .sclk(adc_sclk), .step(step), .hp_next(hp_next)
    );

    adc_pwr_seq #(.QUIET_CYC(QUIET_CYC), .FULL_LEN(FULL_LEN),
                  .CUT_LEN(CUT_LEN), .HPW(HPW)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(conv_req), .psave_sel(psave_mode),
        .step(step), .hp_next(hp_next), .run(run), .cs_n(adc_cs_n),
        .busy(busy), .deliver(deliver), .res_valid(res_valid)
    );

    adc_rx_shift #(.W(RES_W), .LEAD(LEAD_BITS), .HPW(HPW)) u_rx (
        .clk(clk), .rst_n(rst_n), .step(step), .hp_next(hp_next),
        .sdata(adc_sdata), .deliver(deliver), .res_data(res_data)
    );
endmodule

// File: rtl/adc_pwr_ctrl_chk.sv
// Protocol checker for adc_pwr_ctrl, bound to every instance of the top module.
// It counts serial clock falling edges per frame and chip-select-high cycles
// between frames.
module adc_pwr_ctrl_chk #(
    parameter int FULL_LEN  = 16,
    parameter int CUT_LEN   = 12,
    parameter int QUIET_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic conv_req,
    input logic busy,
    input logic res_valid,
    input logic adc_cs_n,
    input logic adc_sclk
);
    localparam int FCW = $clog2(FULL_LEN + 2);
    localparam int HCW = $clog2(QUIET_CYC + 1);

    logic           sclk_d;
    logic           cs_d;
    logic [FCW-1:0] fcnt;
    logic [HCW-1:0] hcnt;

    // Count falling edges of the serial clock inside the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b1;
            cs_d   <= 1'b1;
            fcnt   <= '0;
        end else begin
            sclk_d <= adc_sclk;
            cs_d   <= adc_cs_n;
            if (cs_d && !adc_cs_n)                     fcnt <= '0;
            else if (!adc_cs_n && sclk_d && !adc_sclk) fcnt <= fcnt + 1'b1;
        end
    end

    // Count cycles with chip select high, saturating at the required gap.
    always_ff @(posedge clk) begin
        if (!rst_n)                          hcnt <= HCW'(QUIET_CYC);
        else if (!adc_cs_n)                  hcnt <= '0;
        else if (hcnt < HCW'(QUIET_CYC))     hcnt <= hcnt + 1'b1;
    end

    assert_frame_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (fcnt == FCW'(FULL_LEN) || fcnt == FCW'(CUT_LEN)));

    assert_quiet_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (hcnt >= HCW'(QUIET_CYC)));

    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> adc_sclk);

    assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && conv_req) |=> busy);

    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_valid_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !busy);
endmodule

bind adc_pwr_ctrl adc_pwr_ctrl_chk #(
    .FULL_LEN(FULL_LEN), .CUT_LEN(CUT_LEN), .QUIET_CYC(QUIET_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .busy(busy),
    .res_valid(res_valid), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk)
);

// File: tb/sim_adc_pwr_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench. The driver pushes the word expected for each request,
// and the monitor pops and compares on every result strobe. A converter
// model changes its data word on every frame and keeps its own sleep state.
module sim_adc_pwr_ctrl;
    localparam int DIV   = 3;
    localparam int QUIET = 7;
    localparam int W     = 8;
    localparam int LEAD  = 3;
    localparam int FULL  = 16;
    localparam int CUT   = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_req = 1'b0;
    logic         psave_mode = 1'b0;
    logic         busy;
    logic [W-1:0] res_data;
    logic         res_valid;
    logic         adc_cs_n;
    logic         adc_sclk;
    logic         adc_sdata = 1'b0;

    int nchk = 0;
    int nerr = 0;

    adc_pwr_ctrl #(.CLK_DIV(DIV), .RES_W(W), .LEAD_BITS(LEAD), .FULL_LEN(FULL),
                   .CUT_LEN(CUT), .QUIET_CYC(QUIET)) u0 (
        .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .psave_mode(psave_mode),
        .busy(busy), .res_data(res_data), .res_valid(res_valid),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_sdata(adc_sdata)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    // Data word the converter sends in frame n.
    function automatic logic [W-1:0] dat(input int n);
        return W'(n * 73 + 90);
    endfunction

    // Frame bit i of frame n: the data word sits at indices LEAD..LEAD+W-1, MSB first.
    function automatic logic sbit(input int n, input int i);
        logic [W-1:0] d;
        d = dat(n);
        if (i >= LEAD && i < LEAD + W) return d[W-1-(i-LEAD)];
        return 1'b0;
    endfunction

    // Converter model
    int  frames_seen = 0;
    int  cur_n = 0;
    int  bidx = 0;
    int  nfall = 0;
    bit  started = 0;
    bit  mdl_asleep = 1;
    bit  cur_dummy = 0;
    bit  last_valid = 0;
    bit  drv_psave = 0;

    always @(negedge adc_cs_n) begin
        started = 1;
        cur_n = frames_seen;
        frames_seen++;
        bidx = 0;
        nfall = 0;
        cur_dummy = mdl_asleep;
        adc_sdata = sbit(cur_n, 0);
    end

    always @(negedge adc_sclk) begin
        if (!adc_cs_n) begin
            nfall++;
            bidx++;
            adc_sdata = sbit(cur_n, bidx);
        end
    end

    always @(posedge adc_cs_n) begin
        if (started) begin
            if (cur_dummy || !drv_psave)
                chk(nfall == FULL, "R5 full frame falling edges", nfall, FULL);
            else
                chk(nfall == CUT, "R6 power-save frame falling edges", nfall, CUT);
            last_valid = !cur_dummy;
            if (nfall >= 10 && nfall < 15) mdl_asleep = 1;
            else if (nfall >= 16)          mdl_asleep = 0;
        end
    end

    // Sampled checks: quiet gap, serial clock period, idle level.
    int cyc = 0;
    int hi_cnt = 1000;
    int last_fall = 0;
    bit have_fall = 0;
    bit sclk_p = 1;
    int idle_bad = 0;
    bit rv_p = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (adc_cs_n) begin
                hi_cnt++;
                have_fall = 0;
                if (!adc_sclk) idle_bad++;
            end else begin
                if (hi_cnt != 0) chk(hi_cnt >= QUIET, "R4 quiet gap", hi_cnt, QUIET);
                hi_cnt = 0;
                if (sclk_p && !adc_sclk) begin
                    if (have_fall) chk(cyc - last_fall == 2 * DIV, "R5 sclk period", cyc - last_fall, 2 * DIV);
                    have_fall = 1;
                    last_fall = cyc;
                end
            end
            if (rv_p) chk(!res_valid, "R9 valid single cycle", res_valid, 0);
        end
        sclk_p = adc_sclk;
        rv_p = res_valid;
    end

    // Scoreboard
    logic [W-1:0] exp_q[$];
    int  exp_frames = 0;
    bit  exp_asleep = 1;

    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            chk(!busy, "R9 busy low with result", busy, 0);
            chk(last_valid, "R2 result from post-wake frame", last_valid, 1);
            if (exp_q.size() == 0) begin
                chk(0, "R2 unexpected result", 1, 0);
            end else begin
                logic [W-1:0] e;
                e = exp_q.pop_front();
                chk(res_data == e, "R3 R8 result word", res_data, e);
            end
        end
    end

    task automatic convert(input bit ps, input bit hammer);
        drv_psave = ps;
        exp_frames += exp_asleep ? 2 : 1;
        exp_q.push_back(dat(exp_frames - 1));
        exp_asleep = ps;
        @(negedge clk);
        conv_req = 1'b1;
        psave_mode = ps;
        @(negedge clk);
        conv_req = 1'b0;
        chk(busy, "R9 busy after accept", busy, 1);
        if (hammer) begin
            conv_req = 1'b1;
            psave_mode = !ps;
            repeat (10) @(negedge clk);
            conv_req = 1'b0;
            psave_mode = ps;
        end
        while (busy) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(frames_seen == exp_frames, hammer ? "R10 no extra frame" : "R2 R5 frame count",
            frames_seen, exp_frames);
        chk(!busy && adc_cs_n, "R10 idle after result", busy, 0);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 100000) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", wd, 0);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(adc_cs_n && adc_sclk && !busy && !res_valid, "R1 state in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n == 1'b1, "R1 cs high", adc_cs_n, 1);
        chk(adc_sclk == 1'b1, "R1 sclk high", adc_sclk, 1);
        chk(busy == 1'b0, "R1 busy low", busy, 0);
        chk(res_valid == 1'b0, "R1 valid low", res_valid, 0);

        convert(0, 0);   // R2: wake-up frame then valid frame
        convert(0, 0);   // R5: awake, single frame
        convert(0, 0);
        convert(1, 0);   // R6: awake, cut frame
        convert(1, 0);   // R2 R6: dummy then cut frame
        convert(0, 0);   // R2: dummy after shutdown, then full frame
        convert(0, 1);   // R10: requests and mode flips while busy
        convert(1, 1);   // R10 in power-save
        convert(0, 0);

        chk(exp_q.size() == 0, "R2 all results delivered", exp_q.size(), 0);
        chk(idle_bad == 0, "R7 sclk high while cs high", idle_bad, 0);
        report();
    end
endmodule